// File: doc/BRIEF.md
# Exception-Return Frame Sequencer

This block carries out the return-from-exception step of a small processor core. When it is started, it takes the current status word, program counter and the three system stack pointers (interrupt, master, user). It reads the frame that sits on top of the active stack through a 16-bit memory read port. From the 4-bit frame code it decides how many words to restore and how far to move that stack pointer. It then reports the new machine state with a single-cycle completion pulse.

Throwaway frames are popped and the sequence starts again on the stack that the popped status word selects. Such frames can be nested to any depth. The long bus-fault frame is only accepted if a version nibble stored deep in the frame matches the version of the core. An unknown frame code, or a version that does not match, ends the operation with an error pulse and rolls back every register. A coprocessor mid-instruction frame also restores three extra 32-bit values and raises a one-cycle request to read the coprocessor response register.

Top module: `rte_seq`

## Requirements
- R1: After reset, busy, done, fmt_err, cp_req and rd_valid are low, and sr_out, pc_out and all three stack pointer outputs read zero.
- R2: A start pulse taken while idle selects the stack from bit 13 (S) and bit 12 (M) of cur_sr: S=0 user, S=1/M=0 interrupt, S=1/M=1 master. The first read is issued at that stack pointer plus 6, where the frame code word lives (code in bits 15:12).
- R3: Code 0x0: the status word is loaded from SP+0 and the PC from {SP+2, SP+4}. The active pointer advances by 8 and done pulses.
- R4: Code 0x1: the status word is loaded from SP+0 and the active pointer advances by 8. The stack chosen by S/M of the loaded word becomes active, and reading restarts at its pointer plus 6. This chains for any number of throwaway frames across all three stacks.
- R5: Code 0x2: the status word and PC are restored as in R3, and the active pointer advances by 12.
- R6: Code 0x9: the status word and PC are restored, and the active pointer advances by 20. The instruction address comes from {SP+8, SP+10}, the internal register from {SP+12, SP+14} and the effective address from {SP+16, SP+18}. cp_req is high in the same cycle as done.
- R7: Code 0xA: the status word and PC are restored, and the active pointer advances by 32.
- R8: Code 0xB: bits 15:12 of the word at SP+0x36 are compared with CORE_VER. On a match the status word and PC are restored and the pointer advances by 92. On a mismatch fmt_err pulses.
- R9: Any other code, or a version mismatch, pulses fmt_err. sr_out, pc_out and all three pointers then equal the values given at start, even when throwaway frames were already popped. The extra coprocessor outputs are left untouched.
- R10: done and fmt_err are one-cycle pulses and never high together. busy stays high from the cycle after start until the pulse. A start seen while busy is ignored.
- R11: A word is consumed only when rd_valid and rd_ready are both high. While rd_ready is low, rd_valid and rd_addr stay steady, and any number of wait cycles leaves the results unchanged.
- R12: Only the pointer of the stack a frame was read from moves; the other pointers keep their start values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a return operation |
| cur_sr | input | 16 | Status word before the return |
| cur_pc | input | 32 | Program counter before the return |
| cur_isp | input | AW | Interrupt stack pointer before the return |
| cur_msp | input | AW | Master stack pointer before the return |
| cur_usp | input | AW | User stack pointer before the return |
| rd_valid | output | 1 | Read request valid |
| rd_addr | output | AW | Byte address of the requested word |
| rd_ready | input | 1 | Memory accepts the request; rd_data is valid |
| rd_data | input | 16 | Word returned with rd_ready |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: frame restored |
| fmt_err | output | 1 | One-cycle pulse: frame rejected |
| cp_req | output | 1 | One-cycle coprocessor response read request |
| sr_out | output | 16 | Status word after the return |
| pc_out | output | 32 | Program counter after the return |
| isp_out | output | AW | Interrupt stack pointer after the return |
| msp_out | output | AW | Master stack pointer after the return |
| usp_out | output | AW | User stack pointer after the return |
| iaddr_out | output | 32 | Restored instruction address (coprocessor frame) |
| ireg_out | output | 32 | Restored internal register (coprocessor frame) |
| ea_out | output | 32 | Restored effective address (coprocessor frame) |

## Verification
With a memory that never stalls, the result pulse follows the edge that takes start by a fixed number of edges:
- 5 edges for codes 0x0, 0x2 and 0xA.
- 6 edges for code 0xB.
- 11 edges for code 0x9.
- 1 edge for an unknown code.
- 2 more edges for each throwaway frame popped.

Each cycle with rd_ready low adds exactly one edge. The bench samples on the falling edge and checks the first read address one edge after start. It then polls for the pulse with a bounded wait, reads every output in the pulse cycle, and checks on the next falling edge that the pulse has dropped. The exact latency is checked for a normal frame, and one run uses a stalling memory to show that only timing changes.

// File: rtl/rte_pkg.sv
package rte_pkg;

  typedef enum logic [1:0] {STK_USR = 2'd0, STK_INT = 2'd1, STK_MST = 2'd2} stk_e;

  typedef enum logic [2:0] {
    FK_NORMAL, FK_THROW, FK_SIX, FK_CPMID, FK_BUSS, FK_BUSL, FK_BAD
  } fkind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FMT, ST_VER, ST_SR, ST_PCH, ST_PCL, ST_EXT, ST_FIN
  } st_e;

  // S is bit 13, M is bit 12 of the status word
  function automatic stk_e stack_of(input logic [15:0] sr);
    if (!sr[13])     return STK_USR;
    else if (sr[12]) return STK_MST;
    else             return STK_INT;
  endfunction

  function automatic fkind_e kind_of(input logic [3:0] code);
    case (code)
      4'h0:    return FK_NORMAL;
      4'h1:    return FK_THROW;
      4'h2:    return FK_SIX;
      4'h9:    return FK_CPMID;
      4'hA:    return FK_BUSS;
      4'hB:    return FK_BUSL;
      default: return FK_BAD;
    endcase
  endfunction

  // bytes popped from the stack for each frame kind
  function automatic logic [6:0] frame_bytes(input fkind_e k);
    case (k)
      FK_NORMAL, FK_THROW: return 7'd8;
      FK_SIX:              return 7'd12;
      FK_CPMID:            return 7'd20;
      FK_BUSS:             return 7'd32;
      FK_BUSL:             return 7'd92;
      default:             return 7'd0;
    endcase
  endfunction

endpackage

// File: rtl/rte_fmt_decode.sv
module rte_fmt_decode
  import rte_pkg::*;
(
  input  logic [3:0] code,
  output fkind_e     kind,
  output logic [6:0] step_bytes
);
  always_comb begin
    kind       = kind_of(code);
    step_bytes = frame_bytes(kind);
  end
endmodule

// File: rtl/rte_sp_bank.sv
module rte_sp_bank
  import rte_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_isp,
  input  logic [AW-1:0] ld_msp,
  input  logic [AW-1:0] ld_usp,
  input  logic          inc_en,
  input  stk_e          inc_sel,
  input  logic [6:0]    inc_amt,
  output logic [AW-1:0] isp,
  output logic [AW-1:0] msp,
  output logic [AW-1:0] usp
);
  localparam int NSTK = 3;

  logic [AW-1:0] ld_v [NSTK];
  logic [AW-1:0] sp_q [NSTK];

  assign ld_v[int'(STK_USR)] = ld_usp;
  assign ld_v[int'(STK_INT)] = ld_isp;
  assign ld_v[int'(STK_MST)] = ld_msp;

  for (genvar g = 0; g < NSTK; g++) begin : g_sp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              sp_q[g] <= '0;
      else if (ld)                             sp_q[g] <= ld_v[g];
      else if (inc_en && int'(inc_sel) == g)   sp_q[g] <= sp_q[g] + AW'(inc_amt);
    end
  end

  assign usp = sp_q[int'(STK_USR)];
  assign isp = sp_q[int'(STK_INT)];
  assign msp = sp_q[int'(STK_MST)];

  // R12: a pop never moves more than one pointer
  a_r12_one_sp_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !ld) |=> ($countones({isp != $past(isp), msp != $past(msp), usp != $past(usp)}) <= 1));
endmodule

// File: rtl/rte_seq.sv
module rte_seq
  import rte_pkg::*;
#(
  parameter int          AW       = 32,
  parameter logic [3:0]  CORE_VER = 4'h3,
  parameter int          VER_OFS  = 54
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [15:0]   cur_sr,
  input  logic [31:0]   cur_pc,
  input  logic [AW-1:0] cur_isp,
  input  logic [AW-1:0] cur_msp,
  input  logic [AW-1:0] cur_usp,
  output logic          rd_valid,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ready,
  input  logic [15:0]   rd_data,
  output logic          busy,
  output logic          done,
  output logic          fmt_err,
  output logic          cp_req,
  output logic [15:0]   sr_out,
  output logic [31:0]   pc_out,
  output logic [AW-1:0] isp_out,
  output logic [AW-1:0] msp_out,
  output logic [AW-1:0] usp_out,
  output logic [31:0]   iaddr_out,
  output logic [31:0]   ireg_out,
  output logic [31:0]   ea_out
);
  localparam int EXT_WORDS = 6;
  localparam int EXT_CW    = $clog2(EXT_WORDS);

  st_e               st_q;
  stk_e              act_q;
  fkind_e            kind_q;
  logic [6:0]        step_q;
  logic [EXT_CW-1:0] ext_cnt;
  logic [15:0]       sr_q, sr0_q;
  logic [31:0]       pc_q;
  logic [AW-1:0]     snap_isp, snap_msp, snap_usp;
  logic [15:0]       ext_q [EXT_WORDS];
  logic              done_q, err_q, cp_q;

  // named internal events
  logic          beat, ev_start, ev_bad, ev_pop, ev_fin, ver_bad;
  fkind_e        dec_kind;
  logic [6:0]    dec_step;
  logic [AW-1:0] base;
  logic [7:0]    rd_off;

  rte_fmt_decode u_dec (.code(rd_data[15:12]), .kind(dec_kind), .step_bytes(dec_step));

  assign beat     = rd_valid && rd_ready;
  assign ev_start = start && (st_q == ST_IDLE);
  assign ver_bad  = rd_data[15:12] != CORE_VER;
  assign ev_bad   = beat && (((st_q == ST_FMT) && (dec_kind == FK_BAD)) ||
                             ((st_q == ST_VER) && ver_bad));
  assign ev_pop   = beat && (st_q == ST_SR) && (kind_q == FK_THROW);
  assign ev_fin   = (st_q == ST_FIN);

  rte_sp_bank #(.AW(AW)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (ev_start || ev_bad),
    .ld_isp (ev_start ? cur_isp : snap_isp),
    .ld_msp (ev_start ? cur_msp : snap_msp),
    .ld_usp (ev_start ? cur_usp : snap_usp),
    .inc_en (ev_pop || ev_fin),
    .inc_sel(act_q),
    .inc_amt(step_q),
    .isp    (isp_out),
    .msp    (msp_out),
    .usp    (usp_out)
  );

  always_comb begin
    case (act_q)
      STK_MST: base = msp_out;
      STK_INT: base = isp_out;
      default: base = usp_out;
    endcase
    case (st_q)
      ST_FMT:  rd_off = 8'd6;
      ST_VER:  rd_off = 8'(VER_OFS);
      ST_PCH:  rd_off = 8'd2;
      ST_PCL:  rd_off = 8'd4;
      ST_EXT:  rd_off = 8'd8 + 8'({ext_cnt, 1'b0});
      default: rd_off = 8'd0;
    endcase
  end

  assign rd_valid = (st_q != ST_IDLE) && (st_q != ST_FIN);
  assign rd_addr  = base + AW'(rd_off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_isp <= '0; snap_msp <= '0; snap_usp <= '0;
    end else if (ev_start) begin
      snap_isp <= cur_isp; snap_msp <= cur_msp; snap_usp <= cur_usp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      act_q   <= STK_USR;
      kind_q  <= FK_NORMAL;
      step_q  <= '0;
      ext_cnt <= '0;
      sr_q    <= '0;
      sr0_q   <= '0;
      pc_q    <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      cp_q    <= 1'b0;
      for (int i = 0; i < EXT_WORDS; i++) ext_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      cp_q   <= 1'b0;
      if (ev_bad) begin
        err_q <= 1'b1;
        sr_q  <= sr0_q;
        st_q  <= ST_IDLE;
      end else begin
        case (st_q)
          ST_IDLE: if (start) begin
            sr_q  <= cur_sr;
            sr0_q <= cur_sr;
            pc_q  <= cur_pc;
            act_q <= stack_of(cur_sr);
            st_q  <= ST_FMT;
          end
          ST_FMT: if (beat) begin
            kind_q <= dec_kind;
            step_q <= dec_step;
            st_q   <= (dec_kind == FK_BUSL) ? ST_VER : ST_SR;
          end
          ST_VER: if (beat) st_q <= ST_SR;
          ST_SR: if (beat) begin
            sr_q <= rd_data;
            if (kind_q == FK_THROW) begin
              act_q <= stack_of(rd_data);
              st_q  <= ST_FMT;
            end else begin
              st_q <= ST_PCH;
            end
          end
          ST_PCH: if (beat) begin
            pc_q[31:16] <= rd_data;
            st_q        <= ST_PCL;
          end
          ST_PCL: if (beat) begin
            pc_q[15:0] <= rd_data;
            ext_cnt    <= '0;
            st_q       <= (kind_q == FK_CPMID) ? ST_EXT : ST_FIN;
          end
          ST_EXT: if (beat) begin
            ext_q[ext_cnt] <= rd_data;
            if (ext_cnt == EXT_CW'(EXT_WORDS - 1)) st_q <= ST_FIN;
            else ext_cnt <= ext_cnt + EXT_CW'(1);
          end
          ST_FIN: begin
            done_q <= 1'b1;
            cp_q   <= (kind_q == FK_CPMID);
            st_q   <= ST_IDLE;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign fmt_err   = err_q;
  assign cp_req    = cp_q;
  assign sr_out    = sr_q;
  assign pc_out    = pc_q;
  assign iaddr_out = {ext_q[0], ext_q[1]};
  assign ireg_out  = {ext_q[2], ext_q[3]};
  assign ea_out    = {ext_q[4], ext_q[5]};

  // R10: result pulses
  a_r10_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n) !(done && fmt_err));
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r10_err_single: assert property (@(posedge clk) disable iff (!rst_n) fmt_err |=> !fmt_err);
  a_r10_busy_ends_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || fmt_err));
  // R6: coprocessor request only alongside completion
  a_r6_cp_with_done: assert property (@(posedge clk) disable iff (!rst_n) cp_req |-> done);
  // R11: request held while the memory stalls
  a_r11_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));
  // R2: an accepted start issues a read next cycle
  a_r2_start_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> rd_valid);
endmodule

// File: tb/rte_seq_bench.sv
`timescale 1ns/1ps
module rte_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] cur_sr = '0;
  logic [31:0] cur_pc = '0, cur_isp = '0, cur_msp = '0, cur_usp = '0;
  logic        rd_valid, rd_ready, busy, done, fmt_err, cp_req;
  logic [31:0] rd_addr, pc_out, isp_out, msp_out, usp_out, iaddr_out, ireg_out, ea_out;
  logic [15:0] rd_data, sr_out;
  logic        rdy = 1'b1;
  bit          stall = 1'b0;
  logic [15:0] mem [0:511];
  int          n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  assign rd_data  = mem[rd_addr[9:1]];
  assign rd_ready = rdy;
  always @(negedge clk) rdy <= stall ? ~rdy : 1'b1;

  rte_seq u_rte_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cur_sr(cur_sr), .cur_pc(cur_pc),
    .cur_isp(cur_isp), .cur_msp(cur_msp), .cur_usp(cur_usp),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
    .busy(busy), .done(done), .fmt_err(fmt_err), .cp_req(cp_req),
    .sr_out(sr_out), .pc_out(pc_out), .isp_out(isp_out), .msp_out(msp_out),
    .usp_out(usp_out), .iaddr_out(iaddr_out), .ireg_out(ireg_out), .ea_out(ea_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [15:0] v);
    mem[a[9:1]] = v;
  endtask

  task automatic put_frame(input logic [31:0] b, input logic [15:0] sr,
                           input logic [31:0] pc, input logic [3:0] code);
    poke(b, sr);
    poke(b + 2, pc[31:16]);
    poke(b + 4, pc[15:0]);
    poke(b + 6, {code, 12'h0A4});
  endtask

  task automatic run_rte(input logic [15:0] sr, input logic [31:0] pc,
                         input logic [31:0] isp, input logic [31:0] msp, input logic [31:0] usp,
                         input logic [31:0] first, output int lat, output bit got_err,
                         output bit got_cp);
    @(negedge clk);
    cur_sr = sr; cur_pc = pc; cur_isp = isp; cur_msp = msp; cur_usp = usp;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    chk("R2 first read address", rd_addr, first);
    chk("R2 read issued", {31'b0, rd_valid}, 32'd1);
    while (!(done || fmt_err) && lat < 300) begin
      @(negedge clk);
      lat++;
    end
    chk("R10 pulse seen", {31'b0, done || fmt_err}, 32'd1);
    got_err = fmt_err;
    got_cp  = cp_req;
  endtask

  task automatic pulse_drops();
    @(negedge clk);
    chk("R10 pulses last one cycle", {30'b0, done, fmt_err}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 busy/done/err/cp/valid", {27'b0, busy, done, fmt_err, cp_req, rd_valid}, 32'd0);
    chk("R1 sr_out", {16'b0, sr_out}, 32'd0);
    chk("R1 pc_out", pc_out, 32'd0);
    chk("R1 pointers", isp_out | msp_out | usp_out, 32'd0);
  endtask

  task automatic t_normal();
    int lat; bit e, c;
    put_frame(32'h200, 16'h0704, 32'hCAFE_0010, 4'h0);
    run_rte(16'h3000, 32'h1, 32'h100, 32'h200, 32'h300, 32'h206, lat, e, c);
    chk("R3 latency", lat, 32'd5);
    chk("R3 sr", {16'b0, sr_out}, 32'h0704);
    chk("R3 pc", pc_out, 32'hCAFE_0010);
    chk("R3 msp +8", msp_out, 32'h208);
    chk("R12 isp kept", isp_out, 32'h100);
    chk("R12 usp kept", usp_out, 32'h300);
    pulse_drops();
  endtask

  task automatic t_stalled_int();
    int lat; bit e, c;
    put_frame(32'h100, 16'h2512, 32'h0000_4444, 4'h0);
    stall = 1'b1;
    run_rte(16'h2000, 32'h1, 32'h100, 32'h200, 32'h300, 32'h106, lat, e, c);
    stall = 1'b0;
    chk("R11 stalled sr", {16'b0, sr_out}, 32'h2512);
    chk("R11 stalled pc", pc_out, 32'h0000_4444);
    chk("R11 stalled isp", isp_out, 32'h108);
    chk("R11 stalls lengthen run", {31'b0, lat > 5}, 32'd1);
  endtask

  task automatic t_six();
    int lat; bit e, c;
    put_frame(32'h100, 16'h2300, 32'h0BAD_F00D, 4'h2);
    run_rte(16'h2000, 32'h1, 32'h100, 32'h200, 32'h300, 32'h106, lat, e, c);
    chk("R5 pc", pc_out, 32'h0BAD_F00D);
    chk("R5 isp +12", isp_out, 32'h10C);
  endtask

  task automatic t_cp();
    int lat; bit e, c;
    put_frame(32'h300, 16'h0011, 32'h0000_8000, 4'h9);
    for (int k = 0; k < 6; k++) poke(32'h308 + 2 * k, 16'hA000 + 16'(k));
    run_rte(16'h0000, 32'h1, 32'h100, 32'h200, 32'h300, 32'h306, lat, e, c);
    chk("R6 cp_req with done", {31'b0, c}, 32'd1);
    chk("R6 usp +20", usp_out, 32'h314);
    chk("R6 iaddr", iaddr_out, 32'hA000_A001);
    chk("R6 ireg", ireg_out, 32'hA002_A003);
    chk("R6 ea", ea_out, 32'hA004_A005);
    chk("R6 sr", {16'b0, sr_out}, 32'h0011);
    pulse_drops();
  endtask

  task automatic t_buss();
    int lat; bit e, c;
    put_frame(32'h200, 16'h3100, 32'h0000_2222, 4'hA);
    run_rte(16'h3000, 32'h1, 32'h100, 32'h200, 32'h300, 32'h206, lat, e, c);
    chk("R7 done not err", {31'b0, e}, 32'd0);
    chk("R7 msp +32", msp_out, 32'h220);
    chk("R7 pc", pc_out, 32'h0000_2222);
  endtask

  task automatic t_busl();
    int lat; bit e, c;
    put_frame(32'h100, 16'h2700, 32'h0000_7777, 4'hB);
    poke(32'h136, 16'h3ABC);
    run_rte(16'h2000, 32'h1, 32'h100, 32'h200, 32'h300, 32'h106, lat, e, c);
    chk("R8 version match accepted", {31'b0, e}, 32'd0);
    chk("R8 isp +92", isp_out, 32'h15C);
    chk("R8 pc", pc_out, 32'h0000_7777);
    poke(32'h136, 16'h4ABC);
    run_rte(16'h2004, 32'h55, 32'h100, 32'h200, 32'h300, 32'h106, lat, e, c);
    chk("R8 version mismatch err", {31'b0, e}, 32'd1);
    chk("R9 isp unchanged", isp_out, 32'h100);
    chk("R9 sr unchanged", {16'b0, sr_out}, 32'h2004);
    chk("R9 pc unchanged", pc_out, 32'h55);
    pulse_drops();
  endtask

  task automatic t_bad();
    int lat; bit e, c;
    put_frame(32'h300, 16'h0000, 32'h0, 4'h5);
    run_rte(16'h0000, 32'h77, 32'h100, 32'h200, 32'h300, 32'h306, lat, e, c);
    chk("R9 bad code err", {31'b0, e}, 32'd1);
    chk("R9 bad code usp kept", usp_out, 32'h300);
    chk("R9 extras untouched", iaddr_out, 32'hA000_A001);
  endtask

  task automatic t_chain();
    int lat; bit e, c;
    put_frame(32'h100, 16'h3000, 32'h0, 4'h1);
    put_frame(32'h200, 16'h0000, 32'h0, 4'h1);
    put_frame(32'h300, 16'h0015, 32'h1234_5678, 4'h0);
    run_rte(16'h2000, 32'h1, 32'h100, 32'h200, 32'h300, 32'h106, lat, e, c);
    chk("R4 chain done", {31'b0, e}, 32'd0);
    chk("R4 sr from last frame", {16'b0, sr_out}, 32'h0015);
    chk("R4 pc", pc_out, 32'h1234_5678);
    chk("R4 isp +8", isp_out, 32'h108);
    chk("R4 msp +8", msp_out, 32'h208);
    chk("R4 usp +8", usp_out, 32'h308);
    chk("R4 latency two pops", lat, 32'd9);
  endtask

  task automatic t_chain_bad();
    int lat; bit e, c;
    put_frame(32'h100, 16'h3000, 32'h0, 4'h1);
    put_frame(32'h200, 16'h0000, 32'h0, 4'h7);
    run_rte(16'h2000, 32'h99, 32'h100, 32'h200, 32'h300, 32'h106, lat, e, c);
    chk("R9 chained err", {31'b0, e}, 32'd1);
    chk("R9 isp rolled back", isp_out, 32'h100);
    chk("R9 sr rolled back", {16'b0, sr_out}, 32'h2000);
    chk("R9 pc rolled back", pc_out, 32'h99);
  endtask

  task automatic t_busy_start();
    int pulses = 0;
    put_frame(32'h200, 16'h3333, 32'h0000_0ABC, 4'h0);
    put_frame(32'h100, 16'h2222, 32'h0000_0DEF, 4'h0);
    @(negedge clk);
    cur_sr = 16'h3000; cur_isp = 32'h100; cur_msp = 32'h200; cur_usp = 32'h300;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    cur_sr = 16'h2000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (done) pulses++;
    end
    chk("R10 start while busy ignored: one pulse", pulses, 32'd1);
    chk("R10 result from first start", pc_out, 32'h0000_0ABC);
    chk("R10 isp untouched", isp_out, 32'h100);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_normal();
    t_stalled_int();
    t_six();
    t_cp();
    t_buss();
    t_busl();
    t_bad();
    t_chain();
    t_chain_bad();
    t_busy_start();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule